// File: doc/BRIEF.md
# Simulation Step Trigger Controller

This block paces the simulated clock of a logic-evaluating mesh. Each simulated cycle starts with a single-clock pulse on `step_pulse`, which the mesh treats as the simulated rising edge. The mesh reports through `mesh_idle` whether it is quiescent, meaning every node has finished its computation and every message has been delivered. After a pulse, the controller waits for `mesh_idle` to go low and then return high before it counts the cycle as complete. The length of a simulated cycle is therefore set by when the mesh settles, not by a fixed number of clocks.

A host drives one-cycle commands on `cmd_valid`/`cmd_op`. It can start a free run that continues until a stop. It can request a single step. It can request an interval of a given number of cycles, after which `done` rises. It can request a stop, which is honoured only at a cycle boundary. It can request a soft reset, which abandons everything at once. A counter of completed simulated cycles is shown on `cycle_count`.

Top module: `sim_step_sequencer`

## Requirements
- R1: After `rst_n` is released, `step_pulse`, `running` and `done` are 0 and `cycle_count` is 0.
- R2: `step_pulse` is never high for two clocks in a row. It rises only if `mesh_idle` was high at the previous clock edge.
- R3: After a pulse, no further pulse is issued until `mesh_idle` has been seen low and then high again. `cycle_count` increases by exactly one at the edge where `mesh_idle` is seen high again.
- R4: Op code 1 (free run) from the stopped state issues pulses cycle after cycle until a stop or a soft reset.
- R5: Op code 2 (single step) from the stopped state issues exactly one pulse. Once that cycle completes, `running` returns to 0.
- R6: Op code 3 (interval) with `cmd_count` = N > 0 issues exactly N pulses and then sets `done`=1 and `running`=0. With N = 0 it issues no pulse, and `done` is 1 one clock after the command. `done` is never 1 while `running` is 1.
- R7: Op code 4 (stop) during a run lets the current simulated cycle finish and be counted. No pulse follows it.
- R8: Op code 5 (soft reset) in any state gives `running`=0, `done`=0, `step_pulse`=0 and `cycle_count`=0 one clock after the command. No pulse follows until a new start.
- R9: Op codes 1, 2 and 3 are ignored while `running` is 1. Op codes 0, 6 and 7 are ignored in every state.
- R10: A start while `mesh_idle` is low holds `running`=1 with no pulse until `mesh_idle` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe, one cycle per command |
| cmd_op | input | 3 | Command code: 0 none, 1 free run, 2 single step, 3 interval, 4 stop, 5 soft reset |
| cmd_count | input | BUDGET_W | Number of cycles for an interval command |
| mesh_idle | input | 1 | Aggregated quiescence of the mesh |
| step_pulse | output | 1 | Simulated clock edge, one clock wide |
| running | output | 1 | High while a run, step or interval is in progress |
| done | output | 1 | Set when an interval completes; cleared by any start or soft reset |
| cycle_count | output | COUNT_W | Number of completed simulated cycles |

## Verification
Several rules are checked by assertions on every clock:
- the pulse is one clock wide and follows a quiescent sample;
- the cycle counter only steps by one or clears;
- `done` never coexists with `running`;
- `running` falls only at a boundary, in the arming state, or on a soft reset;
- a soft reset leaves the controller quiet on the next clock;
- the interval budget never underflows.

Other behaviour can only be shown by the bench's scenarios: the exact number of pulses per interval under different mesh latencies, the stall while the mesh is held busy or never acknowledges a pulse, and the deferral of a stop to the end of the cycle. The same is true of ignored commands, which the bench checks at the ports.

// File: rtl/sim_step_pkg.sv
package sim_step_pkg;

    typedef enum logic [2:0] {
        ST_PAUSED,
        ST_ARM,
        ST_FIRE,
        ST_WAIT_BUSY,
        ST_WAIT_QUIET
    } step_state_e;

    typedef enum logic [1:0] {
        MODE_FREE,
        MODE_SINGLE,
        MODE_BUDGET
    } run_mode_e;

    localparam logic [2:0] OP_NOP      = 3'd0;
    localparam logic [2:0] OP_RUN      = 3'd1;
    localparam logic [2:0] OP_STEP     = 3'd2;
    localparam logic [2:0] OP_INTERVAL = 3'd3;
    localparam logic [2:0] OP_STOP     = 3'd4;
    localparam logic [2:0] OP_RESET    = 3'd5;

    typedef struct packed {
        logic run;
        logic step;
        logic interval;
        logic stop;
        logic reset;
    } host_req_t;

endpackage

// File: rtl/sim_step_cmd_decode.sv
module sim_step_cmd_decode
    import sim_step_pkg::*;
(
    input  logic      cmd_valid,
    input  logic [2:0] cmd_op,
    output host_req_t req
);

    always_comb begin
        req = '0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_RUN:      req.run      = 1'b1;
                OP_STEP:     req.step     = 1'b1;
                OP_INTERVAL: req.interval = 1'b1;
                OP_STOP:     req.stop     = 1'b1;
                OP_RESET:    req.reset    = 1'b1;
                default:     req          = '0;  // R9: unused codes do nothing
            endcase
        end
    end

endmodule

// File: rtl/sim_step_budget.sv
module sim_step_budget #(
    parameter int BUDGET_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load,
    input  logic [BUDGET_W-1:0] load_val,
    input  logic                consume,
    output logic                last,
    output logic                done
);

    localparam logic [BUDGET_W-1:0] ONE = BUDGET_W'(1);

    typedef struct packed {
        logic [BUDGET_W-1:0] left;
        logic                done;
    } budget_t;

    budget_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.left = '0;
            d.done = 1'b0;
        end else if (load) begin
            d.left = load_val;
            d.done = (load_val == '0);
        end else if (consume) begin
            d.left = q.left - ONE;
            if (q.left == ONE) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign last = (q.left == ONE);
    assign done = q.done;

    AST_BUDGET_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (q.left != '0));  // R6
    AST_BUDGET_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && last && !clear && !load) |=> done);  // R6

endmodule

// File: rtl/sim_step_tally.sv
module sim_step_tally #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               incr,
    output logic [COUNT_W-1:0] count
);

    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
    } tally_t;

    tally_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (incr) begin
            d.cnt = q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count = q.cnt;

    AST_TALLY_STEP_OR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> ((count == $past(count) + ONE) || (count == '0)));  // R3

endmodule

// File: rtl/sim_step_sequencer.sv
module sim_step_sequencer
    import sim_step_pkg::*;
#(
    parameter int COUNT_W  = 32,
    parameter int BUDGET_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [BUDGET_W-1:0] cmd_count,
    input  logic                mesh_idle,
    output logic                step_pulse,
    output logic                running,
    output logic                done,
    output logic [COUNT_W-1:0]  cycle_count
);

    typedef struct packed {
        step_state_e state;
        run_mode_e   mode;
        logic        stop_pend;
    } ctl_t;

    ctl_t      q, d;
    host_req_t req;
    logic      budget_last;
    logic      cycle_done;
    logic      budget_clear;
    logic      budget_load;
    logic      budget_consume;
    logic      paused;

    sim_step_cmd_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .req       (req)
    );

    assign paused = (q.state == ST_PAUSED);

    always_comb begin
        d          = q;
        cycle_done = 1'b0;

        if (req.stop && !paused) begin
            d.stop_pend = 1'b1;
        end

        if (req.reset) begin
            d.state     = ST_PAUSED;
            d.mode      = MODE_FREE;
            d.stop_pend = 1'b0;
        end else begin
            case (q.state)
                ST_PAUSED: begin
                    if (req.run) begin
                        d.mode  = MODE_FREE;
                        d.state = ST_ARM;
                    end else if (req.step) begin
                        d.mode  = MODE_SINGLE;
                        d.state = ST_ARM;
                    end else if (req.interval && (cmd_count != '0)) begin
                        d.mode  = MODE_BUDGET;
                        d.state = ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (d.stop_pend) begin
                        d.state     = ST_PAUSED;
                        d.stop_pend = 1'b0;
                    end else if (mesh_idle) begin
                        d.state = ST_FIRE;
                    end
                end
                ST_FIRE: begin
                    d.state = ST_WAIT_BUSY;
                end
                ST_WAIT_BUSY: begin
                    if (!mesh_idle) begin
                        d.state = ST_WAIT_QUIET;
                    end
                end
                ST_WAIT_QUIET: begin
                    if (mesh_idle) begin
                        cycle_done = 1'b1;
                        if (d.stop_pend || (q.mode == MODE_SINGLE) ||
                            ((q.mode == MODE_BUDGET) && budget_last)) begin
                            d.state     = ST_PAUSED;
                            d.stop_pend = 1'b0;
                        end else begin
                            d.state = ST_FIRE;
                        end
                    end
                end
                default: begin
                    d.state = ST_PAUSED;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_PAUSED;
            q.mode      <= MODE_FREE;
            q.stop_pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign budget_clear   = req.reset || (paused && (req.run || req.step));
    assign budget_load    = paused && req.interval;
    assign budget_consume = cycle_done && (q.mode == MODE_BUDGET) && !req.reset;

    sim_step_budget #(
        .BUDGET_W (BUDGET_W)
    ) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (budget_clear),
        .load     (budget_load),
        .load_val (cmd_count),
        .consume  (budget_consume),
        .last     (budget_last),
        .done     (done)
    );

    sim_step_tally #(
        .COUNT_W (COUNT_W)
    ) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (req.reset),
        .incr  (cycle_done),
        .count (cycle_count)
    );

    assign step_pulse = (q.state == ST_FIRE);
    assign running    = !paused;

    AST_PULSE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> !step_pulse);  // R2
    AST_PULSE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_pulse) |-> $past(mesh_idle));  // R2
    AST_DONE_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);  // R6
    AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> ($past(mesh_idle) || $past(req.reset) || $past(q.state == ST_ARM)));  // R7
    AST_SOFT_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req.reset |=> (!running && !step_pulse && !done && (cycle_count == '0)));  // R8

endmodule

// File: tb/sim_step_sequencer_test.sv
module sim_step_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] cmd_count = 32'd0;
    logic        mesh_idle;
    logic        step_pulse;
    logic        running;
    logic        done;
    logic [31:0] cycle_count;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    int viol = 0;
    int busy = 0;
    int lat = 2;
    bit hang = 1'b0;
    bit force_busy = 1'b0;
    bit prev_pulse = 1'b0;
    bit finished = 1'b0;

    // 50 MHz
    always #10 clk = ~clk;

    sim_step_sequencer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_count   (cmd_count),
        .mesh_idle   (mesh_idle),
        .step_pulse  (step_pulse),
        .running     (running),
        .done        (done),
        .cycle_count (cycle_count)
    );

    // Mesh model: busy for lat clocks after each pulse
    assign mesh_idle = (busy == 0) && !force_busy;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 0;
            prev_pulse <= 1'b0;
        end else begin
            if (step_pulse) begin
                pulses <= pulses + 1;
                if (prev_pulse || busy != 0) viol <= viol + 1;
            end
            prev_pulse <= step_pulse;
            if (step_pulse && !hang) busy <= lat;
            else if (busy != 0) busy <= busy - 1;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [31:0] cnt);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_count = cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
        cmd_count = 32'd0;
    endtask

    task automatic wait_halt(input int max);
        for (int i = 0; i < max && running; i++) @(negedge clk);
    endtask

    task automatic idle_clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // interval count [15:8], mesh latency [7:0]
    localparam logic [15:0] VEC [5] = '{16'h0101, 16'h0302, 16'h0504, 16'h0207, 16'h0801};

    initial begin
        int base;
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "step_pulse", step_pulse, 0);
        chk("R1", "running", running, 0);
        chk("R1", "done", done, 0);
        chk("R1", "cycle_count", cycle_count, 0);

        // R6 / R3 table of interval runs
        for (int i = 0; i < 5; i++) begin
            send(3'd5, 0);
            lat  = int'(VEC[i][7:0]);
            base = pulses;
            send(3'd3, {24'd0, VEC[i][15:8]});
            wait_halt(2000);
            idle_clocks(2);
            chk("R6", "interval pulses", pulses - base, VEC[i][15:8]);
            chk("R3", "interval cycle_count", cycle_count, VEC[i][15:8]);
            chk("R6", "interval done", done, 1);
            chk("R6", "interval running", running, 0);
        end

        // R5 single step
        send(3'd5, 0);
        lat  = 3;
        base = pulses;
        send(3'd2, 0);
        chk("R6", "done cleared by start", done, 0);
        wait_halt(500);
        idle_clocks(5);
        chk("R5", "step pulses", pulses - base, 1);
        chk("R5", "step cycle_count", cycle_count, 1);
        chk("R5", "step running", running, 0);

        // R4 / R7 free run then stop
        send(3'd5, 0);
        base = pulses;
        send(3'd1, 0);
        idle_clocks(40);
        chk("R4", "free run running", running, 1);
        snap = pulses - base;
        chk("R4", "free run several pulses", (snap >= 5) ? 1 : 0, 1);
        send(3'd4, 0);
        wait_halt(500);
        snap = pulses - base;
        chk("R7", "stop counts last cycle", cycle_count, snap);
        idle_clocks(20);
        chk("R7", "no pulse after stop", pulses - base, snap);
        chk("R7", "stopped", running, 0);

        // R6 zero-length interval
        send(3'd5, 0);
        base = pulses;
        send(3'd3, 0);
        chk("R6", "zero interval done", done, 1);
        chk("R6", "zero interval running", running, 0);
        idle_clocks(10);
        chk("R6", "zero interval pulses", pulses - base, 0);

        // R9 start commands ignored while running, unused codes ignored
        send(3'd5, 0);
        lat  = 2;
        base = pulses;
        send(3'd3, 4);
        send(3'd1, 0);
        send(3'd3, 20);
        send(3'd2, 0);
        wait_halt(1000);
        idle_clocks(20);
        chk("R9", "ignored starts pulses", pulses - base, 4);
        chk("R9", "ignored starts count", cycle_count, 4);
        send(3'd6, 0);
        send(3'd7, 0);
        send(3'd0, 0);
        idle_clocks(10);
        chk("R9", "unused codes running", running, 0);
        chk("R9", "unused codes done", done, 1);
        chk("R9", "unused codes count", cycle_count, 4);

        // R10 start while mesh busy
        send(3'd5, 0);
        force_busy = 1'b1;
        base = pulses;
        send(3'd2, 0);
        idle_clocks(10);
        chk("R10", "held running", running, 1);
        chk("R10", "held no pulse", pulses - base, 0);
        force_busy = 1'b0;
        wait_halt(500);
        chk("R10", "released pulses", pulses - base, 1);

        // R3 mesh that never goes busy: no second pulse
        send(3'd5, 0);
        hang = 1'b1;
        base = pulses;
        send(3'd1, 0);
        idle_clocks(30);
        chk("R3", "stalled pulses", pulses - base, 1);
        chk("R3", "stalled count", cycle_count, 0);
        chk("R3", "stalled running", running, 1);

        // R8 soft reset mid-run
        send(3'd5, 0);
        chk("R8", "reset running", running, 0);
        chk("R8", "reset step_pulse", step_pulse, 0);
        hang = 1'b0;
        lat  = 3;
        send(3'd3, 50);
        idle_clocks(25);
        send(3'd5, 0);
        chk("R8", "midrun running", running, 0);
        chk("R8", "midrun count", cycle_count, 0);
        chk("R8", "midrun done", done, 0);
        snap = pulses;
        idle_clocks(20);
        chk("R8", "no pulse after reset", pulses - snap, 0);

        // R2 protocol monitor over the whole run
        chk("R2", "pulse width and quiet violations", viol, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule